// File: doc/BRIEF.md
# E1 Timeslot-Zero Transmit Formatter

The block produces the timeslot-zero octet of a 2.048 Mbit/s PCM30 stream for every frame of a sixteen-frame CRC-4 multiframe. On each frame strobe it samples the frame's position in the multiframe, the four CRC check bits of the current half-multiframe, the two far-end error indication bits and the remote alarm bit. It then emits the octet twice: as a parallel byte that holds until the next strobe, and as an eight-bit serial burst with the most significant bit first.

Even frames carry the fixed alignment word under a CRC bit. Odd frames carry the multiframe alignment or error bits, a constant one, the alarm bit and five national bits. The national bits come from a host-written store. It holds one byte per national bit position, and each bit of that byte belongs to one odd frame. Host writes go to a staging copy that is promoted only at the start of a multiframe. An alarm-indication input forces all ones at once. After reset the block spends one frame time loading its defaults before it accepts strobes.

Top module: `e1_ts0_fmt`

## Requirements
- R1: For INIT_CYCLES clock cycles after reset, `ready` is 0, `ts0_byte` is 8'hFF, `ser_valid` is 0, and frame strobes and host writes are ignored. `ready` then goes to 1 and stays there.
- R2: In a frame with an even `mf_pos`, bits 2 to 8 (`ts0_byte[6:0]`) are 0011011.
- R3: In a frame with an even `mf_pos`, bit 1 (`ts0_byte[7]`) is `crc_in[mf_pos[2:1]]`, where `crc_in[0]` is C1 and `crc_in[3]` is C4.
- R4: In a frame with an odd `mf_pos`, bit 2 (`ts0_byte[6]`) is 1 and bit 3 (`ts0_byte[5]`) equals `alarm_in`.
- R5: Bit 1 of odd frames 1, 3, 5, 7, 9 and 11 is 0, 0, 1, 0, 1, 1 respectively.
- R6: Bit 1 of odd frame 13 is `ebit_in[0]` (E1), and bit 1 of odd frame 15 is `ebit_in[1]` (E2).
- R7: In an odd frame, bits 4 to 8 (`ts0_byte[4:0]`) are Sa4 to Sa8. Sa(4+s) is taken from national byte s (s = 0..4), at bit index k = (mf_pos-1)/2, so bit 0 is frame 1 and bit 7 is frame 15.
- R8: A host write (`nb_we`, `nb_sel` 0..4 selecting Sa4..Sa8, `nb_wdata`) is used only from the next strobe with `mf_pos` = 0. Writes with `nb_sel` above 4 change nothing.
- R9: On the cycle after an accepted strobe, `ts0_byte` shows the new octet and holds it until the next strobe. During the eight cycles after the strobe, `ser_valid` is 1 and `ser_bit` carries bits 1 to 8 in order. Outside those cycles `ser_bit` idles at 1.
- R10: While `ais_force` is 1, `ts0_byte` is 8'hFF and `ser_bit` is 1 in that same cycle. When `ais_force` returns to 0, the latched octet reappears.
- R11: After reset, every national byte holds NB_DEFAULT (8'hFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe marking timeslot zero of a frame |
| mf_pos | input | 4 | Frame index within the CRC-4 multiframe (0..15) |
| crc_in | input | 4 | C1..C4 of the current half-multiframe, C1 in bit 0 |
| ebit_in | input | 2 | E1 in bit 0, E2 in bit 1 |
| alarm_in | input | 1 | Remote alarm bit |
| ais_force | input | 1 | Forces all-ones output while high |
| nb_we | input | 1 | National byte write enable |
| nb_sel | input | 3 | National byte select, 0..4 for Sa4..Sa8 |
| nb_wdata | input | 8 | National byte data, bit k for odd frame 2k+1 |
| ready | output | 1 | Initialisation frame complete |
| ts0_byte | output | 8 | Parallel timeslot-zero octet, bit 1 in bit 7 |
| ser_bit | output | 1 | Serial octet, MSB first |
| ser_valid | output | 1 | High while `ser_bit` carries octet bits |

## Verification
The bench sweeps every multiframe position under several CRC, alarm and error-bit patterns. A swapped C index or an off-by-one in the multiframe alignment table therefore shows up at one specific frame. National bytes with distinct asymmetric patterns are written in the middle of a multiframe. A store that took writes immediately would change frames 9 to 15 too early, and a store with a swapped row and column would scramble the Sa bits. Strobes and writes during the initialisation frame, and a write to an unused select value, expose designs that do not gate them. Alarm indication is raised in the middle of a burst and then released, which catches an override that is registered instead of immediate, or one that corrupts the latched octet.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;
  localparam int OCTET_W  = 8;
  localparam int SA_COUNT = 5;
  localparam int ODD_COLS = 8;

  // bit 1 of an odd frame: alignment pattern, then E1/E2
  function automatic logic odd_lead_bit(input logic [3:0] pos, input logic [1:0] e);
    logic b;
    case (pos[3:1])
      3'd0:    b = 1'b0;
      3'd1:    b = 1'b0;
      3'd2:    b = 1'b1;
      3'd3:    b = 1'b0;
      3'd4:    b = 1'b1;
      3'd5:    b = 1'b1;
      3'd6:    b = e[0];
      default: b = e[1];
    endcase
    return b;
  endfunction

  // sa[0] is Sa4 ... sa[4] is Sa8
  function automatic logic [OCTET_W-1:0] ts0_build(
      input logic [3:0] pos, input logic [3:0] crc, input logic [1:0] e,
      input logic a, input logic [SA_COUNT-1:0] sa);
    logic [OCTET_W-1:0] o;
    if (!pos[0]) begin
      o = {crc[pos[2:1]], 7'b0011011};
    end else begin
      o = {odd_lead_bit(pos, e), 1'b1, a, sa[0], sa[1], sa[2], sa[3], sa[4]};
    end
    return o;
  endfunction
endpackage

// File: rtl/e1_init_timer.sv
module e1_init_timer #(
  parameter int INIT_CYCLES = 256
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      if (cnt == CW'(INIT_CYCLES - 1)) ready <= 1'b1;
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/e1_nb_buffer.sv
module e1_nb_buffer
  import e1_ts0_pkg::*;
#(
  parameter logic [ODD_COLS-1:0] NB_DEFAULT = '1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [2:0]                   wr_sel,
  input  logic [ODD_COLS-1:0]          wr_data,
  input  logic                         promote,
  input  logic [2:0]                   col,
  output logic [SA_COUNT-1:0]          sa_col,
  output logic [SA_COUNT*ODD_COLS-1:0] active_flat
);
  logic [ODD_COLS-1:0] staged [SA_COUNT];
  logic [ODD_COLS-1:0] active [SA_COUNT];

  for (genvar s = 0; s < SA_COUNT; s++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        staged[s] <= NB_DEFAULT;
        active[s] <= NB_DEFAULT;
      end else begin
        if (wr_en && wr_sel == 3'(s)) staged[s] <= wr_data;
        if (promote) active[s] <= staged[s];
      end
    end
    assign sa_col[s] = active[s][col];
    assign active_flat[s*ODD_COLS +: ODD_COLS] = active[s];
  end
endmodule

// File: rtl/e1_ts0_serializer.sv
module e1_ts0_serializer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] data,
  output logic         ser_bit,
  output logic         ser_valid
);
  localparam int CW = $clog2(W + 1);
  logic [W-1:0]  sh;
  logic [CW-1:0] left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
    end else if (load) begin
      sh   <= data;
      left <= CW'(W);
    end else if (left != '0) begin
      sh   <= {sh[W-2:0], 1'b1};
      left <= left - 1'b1;
    end
  end

  assign ser_bit   = sh[W-1];
  assign ser_valid = (left != '0);
endmodule

// File: rtl/e1_ts0_fmt.sv
module e1_ts0_fmt
  import e1_ts0_pkg::*;
#(
  parameter int                  INIT_CYCLES = 256,
  parameter logic [ODD_COLS-1:0] NB_DEFAULT  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         frame_start,
  input  logic [3:0]   mf_pos,
  input  logic [3:0]   crc_in,
  input  logic [1:0]   ebit_in,
  input  logic         alarm_in,
  input  logic         ais_force,
  input  logic         nb_we,
  input  logic [2:0]   nb_sel,
  input  logic [7:0]   nb_wdata,
  output logic         ready,
  output logic [7:0]   ts0_byte,
  output logic         ser_bit,
  output logic         ser_valid
);
  logic                         load_ev;
  logic [3:0]                   load_pos;
  logic                         mf_begin;
  logic [SA_COUNT-1:0]          sa_col;
  logic [SA_COUNT*ODD_COLS-1:0] nb_active;
  logic [OCTET_W-1:0]           octet_q;
  logic [OCTET_W-1:0]           octet_d;
  logic                         ser_raw;

  e1_init_timer #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk(clk), .rst_n(rst_n), .ready(ready)
  );

  assign load_ev  = frame_start && ready;
  assign load_pos = mf_pos;
  assign mf_begin = load_ev && (mf_pos == 4'd0);

  e1_nb_buffer #(.NB_DEFAULT(NB_DEFAULT)) u_nb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(nb_we && ready), .wr_sel(nb_sel), .wr_data(nb_wdata),
    .promote(mf_begin), .col(mf_pos[3:1]),
    .sa_col(sa_col), .active_flat(nb_active)
  );

  assign octet_d = ts0_build(mf_pos, crc_in, ebit_in, alarm_in, sa_col);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       octet_q <= '1;
    else if (load_ev) octet_q <= octet_d;
  end

  e1_ts0_serializer #(.W(OCTET_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .data(octet_d),
    .ser_bit(ser_raw), .ser_valid(ser_valid)
  );

  assign ts0_byte = ais_force ? '1 : octet_q;
  assign ser_bit  = ais_force | ser_raw;
endmodule

// File: rtl/e1_ts0_fmt_chk.sv
module e1_ts0_fmt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ready,
  input logic        ais_force,
  input logic        load_ev,
  input logic [3:0]  load_pos,
  input logic        mf_begin,
  input logic [39:0] nb_active,
  input logic [7:0]  ts0_byte,
  input logic        ser_bit,
  input logic        ser_valid
);
  p_init_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!ser_valid && ts0_byte == 8'hFF));

  p_fas_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && !load_pos[0]) |=> (ais_force || ts0_byte[6:0] == 7'b0011011));

  p_nfas_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ev && load_pos[0]) |=> (ais_force || ts0_byte[6]));

  p_store_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mf_begin |=> $stable(nb_active));

  p_msb_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (ser_valid && (ais_force || ser_bit == ts0_byte[7])));

  p_ais_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ais_force |-> (ts0_byte == 8'hFF && ser_bit));
endmodule

bind e1_ts0_fmt e1_ts0_fmt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .ais_force(ais_force),
  .load_ev(load_ev), .load_pos(load_pos), .mf_begin(mf_begin),
  .nb_active(nb_active), .ts0_byte(ts0_byte), .ser_bit(ser_bit),
  .ser_valid(ser_valid)
);

// File: tb/e1_ts0_fmt_bench.sv
module e1_ts0_fmt_bench;
  localparam int INIT = 256;
  logic clk = 0, rst_n = 0;
  logic frame_start = 0, alarm_in = 0, ais_force = 0, nb_we = 0;
  logic [3:0] mf_pos = 0, crc_in = 0;
  logic [1:0] ebit_in = 0;
  logic [2:0] nb_sel = 0;
  logic [7:0] nb_wdata = 0;
  logic ready, ser_bit, ser_valid;
  logic [7:0] ts0_byte;
  int checks = 0, errors = 0;
  logic [7:0] stg [5];
  logic [7:0] act [5];

  always #2 clk = ~clk;

  e1_ts0_fmt u_e1_ts0_fmt (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .mf_pos(mf_pos),
    .crc_in(crc_in), .ebit_in(ebit_in), .alarm_in(alarm_in),
    .ais_force(ais_force), .nb_we(nb_we), .nb_sel(nb_sel), .nb_wdata(nb_wdata),
    .ready(ready), .ts0_byte(ts0_byte), .ser_bit(ser_bit), .ser_valid(ser_valid)
  );

  task automatic chk(input string req, input int act_v, input int exp_v);
    checks++;
    if (act_v != exp_v) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [7:0] model(input int p, input logic [3:0] c,
                                       input logic [1:0] e, input logic a);
    int k = p / 2;
    int v;
    logic [5:0] mfa = 6'b110100;
    if (p % 2 == 0) return 8'((((c >> (k % 4)) & 1) * 128) + 27);
    if (p == 13) v = e[0];
    else if (p == 15) v = e[1];
    else v = mfa[k];
    v = v * 128 + 64 + a * 32;
    for (int s = 0; s < 5; s++) v += ((act[s] >> k) & 1) << (4 - s);
    return 8'(v);
  endfunction

  task automatic wr(input int sel, input logic [7:0] d);
    @(negedge clk); nb_we = 1; nb_sel = 3'(sel); nb_wdata = d;
    @(negedge clk); nb_we = 0;
    if (sel < 5 && ready) stg[sel] = d;
  endtask

  // send a frame and check parallel and serial output (R9)
  task automatic frame(input int p, input logic [3:0] c, input logic [1:0] e,
                       input logic a, input string req);
    logic [7:0] exp_b;
    @(negedge clk);
    if (p == 0) for (int s = 0; s < 5; s++) act[s] = stg[s];
    exp_b = model(p, c, e, a);
    frame_start = 1; mf_pos = 4'(p); crc_in = c; ebit_in = e; alarm_in = a;
    @(negedge clk); frame_start = 0;
    chk(req, ts0_byte, exp_b);
    for (int i = 0; i < 8; i++) begin
      if (i > 0) @(negedge clk);
      chk("R9 serial", {ser_valid, ser_bit}, {1'b1, exp_b[7-i]});
    end
    @(negedge clk);
    chk("R9 idle", {ser_valid, ser_bit}, 2'b01);
    chk("R9 hold", ts0_byte, exp_b);
  endtask

  initial begin
    for (int s = 0; s < 5; s++) begin stg[s] = 8'hFF; act[s] = 8'hFF; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ready low", ready, 0);
    chk("R1 byte ones", ts0_byte, 8'hFF);
    wr(0, 8'h00);
    @(negedge clk); frame_start = 1; mf_pos = 4'd2; crc_in = 4'h0;
    @(negedge clk); frame_start = 0;
    chk("R1 strobe ignored", {ser_valid, ts0_byte}, {1'b0, 8'hFF});
    repeat (INIT - 12) @(negedge clk);
    chk("R1 still init", ready, 0);
    repeat (10) @(negedge clk);
    chk("R1 ready", ready, 1);
    // defaults (R11) and full sweep of positions
    for (int p = 0; p < 16; p++)
      frame(p, 4'b1010, 2'b01, 1'(p % 3 == 0), "R2 R3 R4 R5 R6 R11 default");
    for (int m = 0; m < 3; m++)
      for (int p = 0; p < 16; p++)
        frame(p, 4'((m * 5 + p) % 16), 2'(m + 1), 1'((p + m) % 2), "R2 R3 R4 R5 R6");
    // store writes mid multiframe (R7 R8)
    for (int p = 0; p < 8; p++) frame(p, 4'h5, 2'b10, 1'b0, "R8 before write");
    wr(0, 8'h35); wr(1, 8'hCA); wr(2, 8'h0F); wr(3, 8'h96); wr(4, 8'h5A);
    wr(5, 8'h00); wr(7, 8'h00);
    for (int p = 8; p < 16; p++) frame(p, 4'h5, 2'b10, 1'b0, "R8 old kept");
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 16; p++) frame(p, 4'h9, 2'b11, 1'b1, "R7 R8 new values");
    // AIS override (R10)
    @(negedge clk);
    frame_start = 1; mf_pos = 4'd5; crc_in = 0; ebit_in = 0; alarm_in = 0;
    @(negedge clk); frame_start = 0; ais_force = 1;
    #0;
    chk("R10 byte ones", ts0_byte, 8'hFF);
    for (int i = 0; i < 8; i++) begin
      chk("R10 serial ones", ser_bit, 1);
      @(negedge clk);
    end
    ais_force = 0;
    #0;
    chk("R10 resume", ts0_byte, model(5, 4'h0, 2'b00, 1'b0));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule